// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It runs two component predictors side by side and lets a third table decide which one to believe. The per-branch component keeps a short record of each branch's own recent outcomes and uses that record to select a counter. The path component uses one shared record of the most recent outcomes across all branches to select a counter. The arbiter table is indexed by the same shared path record and learns, for each path pattern, which component has been more reliable.

A lookup is purely combinational. The fetch logic presents the word-address bits of a branch PC and reads back, in the same cycle, the final guess and both component guesses. When a branch resolves, the execution logic presents its PC bits and actual direction on the update port. The block registers the request and trains all structures on the following clock edge. A separate restore input reloads the shared path record directly, for example after a pipeline flush.

Top module: `tour_bp`

## Requirements
- R1: After reset, every lookup returns not-taken on all three outputs, and the final output follows the path component until the arbiter is trained.
- R2: The per-branch record table has 1024 entries of 10 bits, selected by `lk_pc`/`upd_pc` (PC word-address bits). An update shifts the resolved direction into bit 0 of the selected entry, and older bits move up by one.
- R3: The per-branch counters are 1024 three-bit counters selected by the 10-bit per-branch record. Each starts at 3, and bit 2 gives the component's guess (`pred_local`).
- R4: The path counters are 4096 two-bit counters selected by the 12-bit shared path record. Each starts at 1 and guesses taken at values 2 and 3 (`pred_global`).
- R5: `pred_taken` equals `pred_global` when the arbiter entry at the current path record is 2 or 3, and equals `pred_local` otherwise.
- R6: The arbiter counters (4096 two-bit entries, starting at 2) change only on an update where the two component guesses differ. They count up when the path component was right and down when the per-branch component was right.
- R7: On an update, the shared 12-bit path record shifts left and takes the resolved direction into bit 0.
- R8: An update presented in cycle N changes state at the clock edge that ends cycle N+1. Lookups during cycle N+1 still see the old state, and the counters trained are the ones the lookup would select at that point.
- R9: `ghr_restore` loads `ghr_restore_val` into the shared path record at the next edge. It takes precedence over the shift from an update that applies on the same edge, while that update still trains the counters.
- R10: All counters saturate: a taken update at the maximum value, or a not-taken update at zero, leaves the counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_pc | input | 10 | Lookup PC word-address bits |
| pred_taken | output | 1 | Final direction guess |
| pred_local | output | 1 | Per-branch component guess |
| pred_global | output | 1 | Path component guess |
| upd_valid | input | 1 | Resolved branch present this cycle |
| upd_pc | input | 10 | Resolved branch PC word-address bits |
| upd_taken | input | 1 | Resolved direction, 1 = taken |
| ghr_restore | input | 1 | Reload the shared path record |
| ghr_restore_val | input | 12 | Value loaded on restore |

## Verification
The hardest situation to reach from the ports is an arbiter counter moving far enough to hand a path pattern over to the per-branch component. This needs repeated updates where the two components disagree under the same 12-bit path record, and the per-branch side has to be the correct one. The stimulus reaches it by pinning the path record with restores between updates while a branch with a fixed per-branch pattern trains. It also runs a long pseudo-random mix of branches on a small set of PCs, so that saturation at both limits occurs and updates coincide with restores. Each lookup is compared against a bench model built from the requirements, including lookups placed in the cycle between an update's capture and its effect.

// File: rtl/tdp_pkg.sv
package tdp_pkg;

    // Which component drives the final guess
    typedef enum logic {
        SRC_LOCAL  = 1'b0,
        SRC_GLOBAL = 1'b1
    } src_e;

    // Saturating step for counters up to 8 bits wide
    function automatic logic [7:0] ctr_step(input logic [7:0] cur,
                                            input logic       up,
                                            input logic [7:0] top);
        if (up) begin
            return (cur == top) ? cur : cur + 8'd1;
        end
        return (cur == 8'd0) ? cur : cur - 8'd1;
    endfunction

endpackage

// File: rtl/tdp_hist_table.sv
module tdp_hist_table #(
    parameter int IDX_W = 10,
    parameter int H_W   = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [H_W-1:0]   rd_hist,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_bit,
    output logic [H_W-1:0]   wr_hist
);
    localparam int DEPTH = 1 << IDX_W;

    logic [H_W-1:0] hist_q [DEPTH];
    logic [H_W-1:0] ent_d;

    assign rd_hist = hist_q[rd_idx];
    assign wr_hist = hist_q[wr_idx];

    always_comb begin
        ent_d = {wr_hist[H_W-2:0], wr_bit};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                hist_q[i] <= '0;
            end
        end else if (wr_en) begin
            hist_q[wr_idx] <= ent_d;
        end
    end
endmodule

// File: rtl/tdp_ctr_table.sv
module tdp_ctr_table #(
    parameter int IDX_W   = 10,
    parameter int CTR_W   = 3,
    parameter int RST_VAL = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_msb,
    input  logic             tr_en,
    input  logic [IDX_W-1:0] tr_idx,
    input  logic             tr_up,
    output logic             tr_msb
);
    localparam int         DEPTH = 1 << IDX_W;
    localparam logic [7:0] TOPV  = 8'((1 << CTR_W) - 1);

    logic [CTR_W-1:0] tbl_q [DEPTH];
    logic [CTR_W-1:0] ent_d;

    assign rd_msb = tbl_q[rd_idx][CTR_W-1];
    assign tr_msb = tbl_q[tr_idx][CTR_W-1];

    always_comb begin
        ent_d = CTR_W'(tdp_pkg::ctr_step(8'(tbl_q[tr_idx]), tr_up, TOPV));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                tbl_q[i] <= CTR_W'(RST_VAL);
            end
        end else if (tr_en) begin
            tbl_q[tr_idx] <= ent_d;
        end
    end
endmodule

// File: rtl/tour_bp.sv
module tour_bp #(
    parameter int LH_IDX_W = 10,
    parameter int LH_W     = 10,
    parameter int LCTR_W   = 3,
    parameter int GH_W     = 12,
    parameter int GCTR_W   = 2,
    parameter int CH_W     = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [LH_IDX_W-1:0] lk_pc,
    output logic                pred_taken,
    output logic                pred_local,
    output logic                pred_global,
    input  logic                upd_valid,
    input  logic [LH_IDX_W-1:0] upd_pc,
    input  logic                upd_taken,
    input  logic                ghr_restore,
    input  logic [GH_W-1:0]     ghr_restore_val
);
    import tdp_pkg::*;

    localparam int         LCTR_RST = (1 << (LCTR_W - 1)) - 1;
    localparam int         GCTR_RST = (1 << (GCTR_W - 1)) - 1;
    localparam int         CH_RST   = 1 << (CH_W - 1);
    localparam int         G_DEPTH  = 1 << GH_W;
    localparam logic [7:0] CH_TOP   = 8'((1 << CH_W) - 1);

    typedef struct packed {
        logic                pend;
        logic [LH_IDX_W-1:0] pc;
        logic                tk;
        logic [GH_W-1:0]     ghist;
    } st_t;

    st_t st_d, st_q;

    logic [GH_W-1:0] ghist_cur;
    logic [LH_W-1:0] lk_hist, up_hist;
    logic            lk_lp, lk_gp, up_lp, up_gp;

    logic [CH_W-1:0] ch_q [G_DEPTH];
    logic [CH_W-1:0] ch_d;
    logic            ch_train;
    src_e            pick;

    assign ghist_cur = st_q.ghist;

    tdp_hist_table #(.IDX_W(LH_IDX_W), .H_W(LH_W)) u_lhist (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (lk_pc),
        .rd_hist (lk_hist),
        .wr_en   (st_q.pend),
        .wr_idx  (st_q.pc),
        .wr_bit  (st_q.tk),
        .wr_hist (up_hist)
    );

    tdp_ctr_table #(.IDX_W(LH_W), .CTR_W(LCTR_W), .RST_VAL(LCTR_RST)) u_lctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (lk_hist),
        .rd_msb (lk_lp),
        .tr_en  (st_q.pend),
        .tr_idx (up_hist),
        .tr_up  (st_q.tk),
        .tr_msb (up_lp)
    );

    tdp_ctr_table #(.IDX_W(GH_W), .CTR_W(GCTR_W), .RST_VAL(GCTR_RST)) u_gctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (ghist_cur),
        .rd_msb (lk_gp),
        .tr_en  (st_q.pend),
        .tr_idx (ghist_cur),
        .tr_up  (st_q.tk),
        .tr_msb (up_gp)
    );

    // Next-state computation for the update stage, path record and arbiter entry
    always_comb begin
        st_d      = st_q;
        st_d.pend = upd_valid;
        st_d.pc   = upd_pc;
        st_d.tk   = upd_taken;
        if (st_q.pend) begin
            st_d.ghist = {st_q.ghist[GH_W-2:0], st_q.tk};
        end
        if (ghr_restore) begin
            st_d.ghist = ghr_restore_val;
        end

        ch_train = st_q.pend && (up_lp != up_gp);
        ch_d     = CH_W'(ctr_step(8'(ch_q[ghist_cur]), up_gp == st_q.tk, CH_TOP));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < G_DEPTH; i++) begin
                ch_q[i] <= CH_W'(CH_RST);
            end
        end else if (ch_train) begin
            ch_q[ghist_cur] <= ch_d;
        end
    end

    assign pick        = src_e'(ch_q[ghist_cur][CH_W-1]);
    assign pred_local  = lk_lp;
    assign pred_global = lk_gp;
    assign pred_taken  = (pick == SRC_GLOBAL) ? lk_gp : lk_lp;
endmodule

// File: rtl/tour_bp_chk.sv
module tour_bp_chk #(
    parameter int GH_W = 12
) (
    input logic            clk,
    input logic            rst_n,
    input logic            upd_valid,
    input logic            upd_taken,
    input logic            ghr_restore,
    input logic [GH_W-1:0] ghr_restore_val,
    input logic [GH_W-1:0] ghist_cur,
    input logic            pred_taken,
    input logic            pred_local,
    input logic            pred_global
);
    AST_FINAL_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_local == pred_global) |-> (pred_taken == pred_local)); // R5

    AST_PATH_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(upd_valid) && !ghr_restore)
        |=> (ghist_cur == {$past(ghist_cur[GH_W-2:0]), $past(upd_taken, 2)})); // R7

    AST_PATH_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
        ghr_restore |=> (ghist_cur == $past(ghr_restore_val))); // R9

    AST_PATH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(upd_valid) && !ghr_restore) |=> $stable(ghist_cur)); // R8

    AST_PRED_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown({pred_taken, pred_local, pred_global})); // R5
endmodule

bind tour_bp tour_bp_chk #(.GH_W(GH_W)) u_tour_bp_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .upd_valid       (upd_valid),
    .upd_taken       (upd_taken),
    .ghr_restore     (ghr_restore),
    .ghr_restore_val (ghr_restore_val),
    .ghist_cur       (ghist_cur),
    .pred_taken      (pred_taken),
    .pred_local      (pred_local),
    .pred_global     (pred_global)
);

// File: tb/tour_bp_bench.sv
module tour_bp_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  lk_pc = '0;
    logic        pred_taken, pred_local, pred_global;
    logic        upd_valid = 1'b0;
    logic [9:0]  upd_pc = '0;
    logic        upd_taken = 1'b0;
    logic        ghr_restore = 1'b0;
    logic [11:0] ghr_restore_val = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tour_bp u_tour_bp (
        .clk             (clk),
        .rst_n           (rst_n),
        .lk_pc           (lk_pc),
        .pred_taken      (pred_taken),
        .pred_local      (pred_local),
        .pred_global     (pred_global),
        .upd_valid       (upd_valid),
        .upd_pc          (upd_pc),
        .upd_taken       (upd_taken),
        .ghr_restore     (ghr_restore),
        .ghr_restore_val (ghr_restore_val)
    );

    // Reference model built from the requirements
    bit [9:0]  mlh [1024];
    bit [2:0]  mlc [1024];
    bit [1:0]  mgc [4096];
    bit [1:0]  mch [4096];
    bit [11:0] mgh;

    typedef struct {
        int       req;
        bit [9:0] pc;
        bit       el;
        bit       eg;
        bit       et;
    } item_t;

    item_t sb_q[$];
    int    checks = 0;
    int    fails  = 0;
    bit    done   = 1'b0;

    function automatic bit [2:0] step3(bit [2:0] v, bit up);
        if (up) return (v == 3'd7) ? v : v + 3'd1;
        return (v == 3'd0) ? v : v - 3'd1;
    endfunction

    function automatic bit [1:0] step2(bit [1:0] v, bit up);
        if (up) return (v == 2'd3) ? v : v + 2'd1;
        return (v == 2'd0) ? v : v - 2'd1;
    endfunction

    function automatic void model_reset();
        for (int i = 0; i < 1024; i++) begin
            mlh[i] = '0;
            mlc[i] = 3'd3;   // R3 weakly not-taken
        end
        for (int i = 0; i < 4096; i++) begin
            mgc[i] = 2'd1;   // R4 weakly not-taken
            mch[i] = 2'd2;   // R6 weakly favours path component
        end
        mgh = '0;
    endfunction

    function automatic void model_update(bit [9:0] pc, bit tk);
        bit [9:0] h;
        bit       lp, gp;
        h  = mlh[pc];
        lp = mlc[h][2];
        gp = mgc[mgh][1];
        if (lp != gp) mch[mgh] = step2(mch[mgh], gp == tk);   // R6
        mlc[h]   = step3(mlc[h], tk);                          // R3 R10
        mgc[mgh] = step2(mgc[mgh], tk);                        // R4 R10
        mlh[pc]  = {h[8:0], tk};                               // R2
        mgh      = {mgh[10:0], tk};                            // R7
    endfunction

    function automatic item_t expect_for(bit [9:0] pc, int req);
        item_t it;
        it.req = req;
        it.pc  = pc;
        it.el  = mlc[mlh[pc]][2];
        it.eg  = mgc[mgh][1];
        it.et  = mch[mgh][1] ? it.eg : it.el;   // R5
        return it;
    endfunction

    // Driver tasks
    task automatic lookup(bit [9:0] pc, int req);
        @(posedge clk); #1;
        lk_pc = pc;
        sb_q.push_back(expect_for(pc, req));
    endtask

    task automatic update(bit [9:0] pc, bit tk);
        @(posedge clk); #1;
        upd_valid = 1'b1;
        upd_pc    = pc;
        upd_taken = tk;
        @(posedge clk); #1;
        upd_valid = 1'b0;
        // R8: lookup in the cycle before the state changes sees old state
        lk_pc = pc;
        sb_q.push_back(expect_for(pc, 8));
        @(posedge clk);
        model_update(pc, tk);
    endtask

    task automatic restore(bit [11:0] v);
        @(posedge clk); #1;
        ghr_restore     = 1'b1;
        ghr_restore_val = v;
        @(posedge clk); #1;
        ghr_restore = 1'b0;
        mgh = v;
    endtask

    task automatic update_with_restore(bit [9:0] pc, bit tk, bit [11:0] v);
        @(posedge clk); #1;
        upd_valid = 1'b1;
        upd_pc    = pc;
        upd_taken = tk;
        @(posedge clk); #1;
        upd_valid       = 1'b0;
        ghr_restore     = 1'b1;
        ghr_restore_val = v;
        @(posedge clk); #1;
        ghr_restore = 1'b0;
        model_update(pc, tk);
        mgh = v;   // R9 restore wins over the shift
    endtask

    // Monitor: compare away from the active edge
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                checks++;
                if ({pred_local, pred_global, pred_taken} !== {it.el, it.eg, it.et}) begin
                    fails++;
                    $display("FAIL R%0d pc=%h local/global/final actual=%b%b%b expected=%b%b%b",
                             it.req, it.pc, pred_local, pred_global, pred_taken,
                             it.el, it.eg, it.et);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        bit [15:0] lfsr;
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state, all not-taken
        lookup(10'h000, 1);
        lookup(10'h001, 1);
        lookup(10'h3FF, 1);
        lookup(10'h123, 1);

        // R2 R3: one branch taken repeatedly, its own record grows
        for (int i = 0; i < 4; i++) begin
            update(10'h040, 1'b1);
            lookup(10'h040, 2);
            lookup(10'h041, 3);
        end

        // R10: drive counters into saturation at the top and back to zero
        for (int i = 0; i < 16; i++) begin
            update(10'h040, 1'b1);
            lookup(10'h040, 10);
        end
        for (int i = 0; i < 16; i++) begin
            update(10'h040, 1'b0);
            lookup(10'h040, 10);
        end

        // R4 R7: path record built from a mixed direction sequence
        for (int i = 0; i < 12; i++) begin
            update(10'(i * 7), (i % 3) != 0);
            lookup(10'h200, 4);
            lookup(10'(i * 7), 7);
        end

        // R6: pin the path record; per-branch side learns an alternating branch
        for (int i = 0; i < 40; i++) begin
            restore(12'h5A5);
            update(10'h0AA, i[0]);
            restore(12'h5A5);
            lookup(10'h0AA, 6);
        end

        // R9: plain restore, then restore coinciding with an update
        restore(12'hABC);
        lookup(10'h0AA, 9);
        update_with_restore(10'h0AA, 1'b1, 12'h5A5);
        lookup(10'h0AA, 9);
        update_with_restore(10'h0AB, 1'b0, 12'h001);
        lookup(10'h0AB, 9);

        // R5: long pseudo-random mix on a few branches
        lfsr = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            bit [9:0] pc;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            pc   = {7'd0, lfsr[2:0]};
            if (lfsr[9:4] == 6'd0) begin
                update_with_restore(pc, lfsr[3] | lfsr[7], {lfsr[11:0]});
            end else begin
                update(pc, (pc[0] ? lfsr[3] | lfsr[5] : pc[1]));
            end
            lookup(pc, 5);
        end

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule